// File: doc/BRIEF.md
# Dual Multi-Mode Down-Counter Timer

This block holds two independent 32-bit down-counting timer channels behind a simple word-addressed register port. Each channel has a control word, a reload word and a current-count word. A channel is halted, free-running, auto-reloading or producing a square wave. It counts one step on every cycle in which the shared `tick` input is high and three conditions hold: its mode is not halt, its software run bit is set, and its own hardware enable pin matches a programmable polarity.

A channel whose count is zero and which receives a counting tick has a zero event. What happens next depends on the mode. The count reloads in auto-reload and wave modes. In free-running mode it wraps to all ones, or it rests at zero if wrapping is off. A zero event sets a pending flag. That flag drives the channel's interrupt output when the interrupt enable bit is set, and any write to the control word clears it. In wave mode the channel's status output toggles on every zero event, so the output period is twice (reload + 1) ticks.

Top module: `tmr_pair`

## Requirements
- R1: After a synchronous active-low reset, every register of both channels reads 0, and `irq` and `pwm_out` are 0.
- R2: The register word index is `addr[3:0]`. Bit 3 selects the channel. Bits 2:0 select the word: 0 is control, 1 is reload, 2 is current count. Words 3 to 7 read 0 and ignore writes. Reads are combinational.
- R3: The control word uses these bits: bit 22 interrupt enable, bit 21 wrap-through-zero, bits 20:19 mode (0 halt, 1 free, 2 auto-reload, 3 wave), bit 18 software run, bit 17 enable polarity, bit 16 status (read-only). All other bits read 0.
- R4: The count decrements by 1 on a tick when three conditions hold: mode ≠ 0, the run bit is 1, and `hw_en` of the channel equals the polarity bit. Otherwise the count holds.
- R5: In auto-reload mode, a counting tick at count 0 loads the reload value and is a zero event.
- R6: In free mode, a counting tick at count 0 loads all ones and is a zero event when wrap is 1. When wrap is 0, the count stays 0 and there is no event.
- R7: In wave mode, a counting tick at count 0 loads the reload value, is a zero event, and toggles the status (`pwm_out` and control bit 16). Writing the control word with a mode other than 3 clears the status.
- R8: A zero event sets the channel's pending flag, and `irq` equals pending AND interrupt enable. A write to the control word clears the pending flag.
- R9: Writing the reload word while the channel is not counting also loads the count. While it is counting, only the reload word changes.
- R10: The count word is writable. Any write to one of a channel's three words drops that channel's tick in that cycle.
- R11: The two channels are independent. Stimulus to one channel leaves the other channel's registers and outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Count tick, shared by both channels |
| hw_en | input | 2 | Per-channel hardware enable |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register word index |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data (combinational) |
| irq | output | 2 | Per-channel interrupt |
| pwm_out | output | 2 | Per-channel status / wave output |

## Verification
All state is registered. A write or tick presented before a rising edge shows up in the count, `irq` and `pwm_out` right after that edge. A read shows the addressed register in the same cycle, with no added latency. The bench drives inputs on the falling edge. It compares `irq` and `pwm_out` 1 ns after the following rising edge, and it compares read data 1 ns after setting the address with no write and no tick, so no state moves during the read. Expected values come from a bench-side model of the requirements that advances once per driven cycle.

// File: rtl/tmr_pkg.sv
// Shared constants and types for the dual down-counter timer.
// Assumes a 32-bit register data path; field positions are fixed.
package tmr_pkg;
    localparam int DW      = 32;
    localparam int WORD_BW = 3;     // eight words per channel
    localparam int IE_B    = 22;
    localparam int WRAP_B  = 21;
    localparam int MODE_LO = 19;
    localparam int SW_B    = 18;
    localparam int POL_B   = 17;
    localparam int STAT_B  = 16;
    localparam logic [WORD_BW-1:0] W_CTRL = 3'd0;
    localparam logic [WORD_BW-1:0] W_RLD  = 3'd1;
    localparam logic [WORD_BW-1:0] W_CUR  = 3'd2;

    typedef enum logic [1:0] {
        M_HALT   = 2'd0,
        M_FREE   = 2'd1,
        M_RELOAD = 2'd2,
        M_WAVE   = 2'd3
    } tmr_mode_e;

    typedef struct packed {
        logic      ie;
        logic      wrap;
        tmr_mode_e mode;
        logic      sw;
        logic      pol;
    } tmr_ctrl_t;
endpackage

// File: rtl/tmr_chan.sv
// One timer channel: control, reload and count registers, zero-event
// logic, pending flag and wave/status toggle.
// Assumes CW <= DW and at most one register write per cycle.
module tmr_chan
    import tmr_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          hw_en,
    input  logic          wr_ctrl,
    input  logic          wr_rld,
    input  logic          wr_cur,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rd_ctrl,
    output logic [DW-1:0] rd_rld,
    output logic [DW-1:0] rd_cur,
    output logic [CW-1:0] cur_o,
    output logic          irq,
    output logic          stat,
    output logic          run,
    output logic          evt,
    output logic          pend
);
    tmr_ctrl_t     ctrl_q;
    logic [CW-1:0] rld_q, cur_q, cur_d;
    logic          stat_q, pend_q, any_wr, cnt;

    // Counting qualification: mode, software request and pin polarity.
    assign run    = (ctrl_q.mode != M_HALT) && ctrl_q.sw && (hw_en == ctrl_q.pol);
    assign any_wr = wr_ctrl | wr_rld | wr_cur;
    assign cnt    = tick && run && !any_wr;

    // Next count value and zero-event detection.
    always_comb begin
        cur_d = cur_q;
        evt   = 1'b0;
        if (wr_cur) begin
            cur_d = wdata[CW-1:0];
        end else if (wr_rld && !run) begin
            cur_d = wdata[CW-1:0];
        end else if (cnt) begin
            if (cur_q != '0) begin
                cur_d = cur_q - 1'b1;
            end else begin
                case (ctrl_q.mode)
                    M_FREE: if (ctrl_q.wrap) begin
                        cur_d = '1;
                        evt   = 1'b1;
                    end
                    M_RELOAD, M_WAVE: begin
                        cur_d = rld_q;
                        evt   = 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // Register update: control, reload, count, status and pending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            rld_q  <= '0;
            cur_q  <= '0;
            stat_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            cur_q <= cur_d;
            if (wr_rld) rld_q <= wdata[CW-1:0];
            if (wr_ctrl) begin
                ctrl_q <= '{ie:   wdata[IE_B],
                            wrap: wdata[WRAP_B],
                            mode: tmr_mode_e'(wdata[MODE_LO+1:MODE_LO]),
                            sw:   wdata[SW_B],
                            pol:  wdata[POL_B]};
                if (wdata[MODE_LO+1:MODE_LO] != M_WAVE) stat_q <= 1'b0;
            end else if (evt && ctrl_q.mode == M_WAVE) begin
                stat_q <= ~stat_q;
            end
            if (evt) pend_q <= 1'b1;
            else if (wr_ctrl) pend_q <= 1'b0;
        end
    end

    // Read-back words.
    always_comb begin
        rd_ctrl                     = '0;
        rd_ctrl[IE_B]               = ctrl_q.ie;
        rd_ctrl[WRAP_B]             = ctrl_q.wrap;
        rd_ctrl[MODE_LO+1:MODE_LO]  = ctrl_q.mode;
        rd_ctrl[SW_B]               = ctrl_q.sw;
        rd_ctrl[POL_B]              = ctrl_q.pol;
        rd_ctrl[STAT_B]             = stat_q;
    end
    assign rd_rld = DW'(rld_q);
    assign rd_cur = DW'(cur_q);
    assign cur_o  = cur_q;
    assign irq    = pend_q & ctrl_q.ie;
    assign stat   = stat_q;
    assign pend   = pend_q;
endmodule

// File: rtl/tmr_regif.sv
// Register port decode: splits the word index into channel and word,
// raises per-channel write strobes and selects read data.
// Assumes each channel presents its three words packed ctrl, reload, count.
module tmr_regif
    import tmr_pkg::*;
#(
    parameter int NCH = 2,
    parameter int AW  = 4
) (
    input  logic               wr_en,
    input  logic [AW-1:0]      addr,
    input  logic [NCH*3*DW-1:0] rd_words,
    output logic [NCH-1:0]     wr_ctrl,
    output logic [NCH-1:0]     wr_rld,
    output logic [NCH-1:0]     wr_cur,
    output logic [DW-1:0]      rd_data
);
    localparam int CHW = AW - WORD_BW;

    logic [CHW-1:0]     ch;
    logic [WORD_BW-1:0] word;
    logic [NCH-1:0]     hit;

    assign ch   = addr[AW-1:WORD_BW];
    assign word = addr[WORD_BW-1:0];

    // Per-channel address match and write strobes.
    for (genvar c = 0; c < NCH; c++) begin : g_dec
        assign hit[c]     = (ch == CHW'(c));
        assign wr_ctrl[c] = wr_en && hit[c] && (word == W_CTRL);
        assign wr_rld[c]  = wr_en && hit[c] && (word == W_RLD);
        assign wr_cur[c]  = wr_en && hit[c] && (word == W_CUR);
    end

    // Read data select; unmapped words return zero.
    always_comb begin
        rd_data = '0;
        for (int c = 0; c < NCH; c++) begin
            if (hit[c]) begin
                case (word)
                    W_CTRL:  rd_data = rd_words[(c*3+0)*DW +: DW];
                    W_RLD:   rd_data = rd_words[(c*3+1)*DW +: DW];
                    W_CUR:   rd_data = rd_words[(c*3+2)*DW +: DW];
                    default: rd_data = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/tmr_pair.sv
// Top: NCH independent timer channels behind one word-addressed port.
// Assumes a single-cycle write strobe and a shared tick input.
module tmr_pair
    import tmr_pkg::*;
#(
    parameter  int NCH = 2,
    parameter  int CW  = 32,
    localparam int AW  = WORD_BW + ((NCH > 1) ? $clog2(NCH) : 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic [NCH-1:0] hw_en,
    input  logic           wr_en,
    input  logic [AW-1:0]  addr,
    input  logic [DW-1:0]  wdata,
    output logic [DW-1:0]  rd_data,
    output logic [NCH-1:0] irq,
    output logic [NCH-1:0] pwm_out
);
    logic [NCH-1:0]        wr_ctrl, wr_rld, wr_cur;
    logic [NCH*3*DW-1:0]   rd_words;
    logic [NCH*CW-1:0]     cur_flat;
    logic [NCH-1:0]        run_v, evt_v, pend_v;

    tmr_regif #(.NCH(NCH), .AW(AW)) u_regif (
        .wr_en   (wr_en),
        .addr    (addr),
        .rd_words(rd_words),
        .wr_ctrl (wr_ctrl),
        .wr_rld  (wr_rld),
        .wr_cur  (wr_cur),
        .rd_data (rd_data)
    );

    // One channel instance per timer.
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        tmr_chan #(.CW(CW)) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (tick),
            .hw_en  (hw_en[c]),
            .wr_ctrl(wr_ctrl[c]),
            .wr_rld (wr_rld[c]),
            .wr_cur (wr_cur[c]),
            .wdata  (wdata),
            .rd_ctrl(rd_words[(c*3+0)*DW +: DW]),
            .rd_rld (rd_words[(c*3+1)*DW +: DW]),
            .rd_cur (rd_words[(c*3+2)*DW +: DW]),
            .cur_o  (cur_flat[c*CW +: CW]),
            .irq    (irq[c]),
            .stat   (pwm_out[c]),
            .run    (run_v[c]),
            .evt    (evt_v[c]),
            .pend   (pend_v[c])
        );
    end
endmodule

// File: rtl/tmr_chk.sv
// Assertion checker for tmr_pair, attached by bind.
// Assumes the top exposes cur_flat, run_v, evt_v and pend_v.
module tmr_chk #(
    parameter int NCH = 2,
    parameter int CW  = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            tick,
    input logic            wr_en,
    input logic [NCH-1:0]  irq,
    input logic [NCH-1:0]  pwm_out,
    input logic [NCH-1:0]  run_v,
    input logic [NCH-1:0]  evt_v,
    input logic [NCH-1:0]  pend_v,
    input logic [NCH*CW-1:0] cur_flat
);
    for (genvar i = 0; i < NCH; i++) begin : g_a
        // R4: a halted channel keeps its count when nothing is written
        assert_hold_halted_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (!run_v[i] && !wr_en) |=> $stable(cur_flat[i*CW +: CW]));
        // R4: a counting tick above zero decrements by one
        assert_count_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (run_v[i] && tick && !wr_en && cur_flat[i*CW +: CW] != '0)
            |=> (cur_flat[i*CW +: CW] == $past(cur_flat[i*CW +: CW]) - 1'b1));
        // R5: zero events occur only on a tick at count zero
        assert_evt_at_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
            evt_v[i] |-> (tick && cur_flat[i*CW +: CW] == '0));
        // R8: a zero event leaves the pending flag set
        assert_evt_pend_R8: assert property (@(posedge clk) disable iff (!rst_n)
            evt_v[i] |=> pend_v[i]);
        // R8: interrupt only with pending set
        assert_irq_pend_R8: assert property (@(posedge clk) disable iff (!rst_n)
            irq[i] |-> pend_v[i]);
        // R7: the status output moves only on an event or a write
        assert_stat_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (!evt_v[i] && !wr_en) |=> $stable(pwm_out[i]));
    end
endmodule

bind tmr_pair tmr_chk #(.NCH(NCH), .CW(CW)) u_chk (.*);

// File: tb/sim_tmr_pair.sv
module sim_tmr_pair;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [1:0]  hw_en = 2'b00;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = 4'd0;
    logic [31:0] wdata = 32'd0;
    logic [31:0] rd_data;
    logic [1:0]  irq, pwm_out;

    int  nchk = 0;
    int  nfail = 0;
    bit  done = 1'b0;

    // Bench-side model state
    logic [31:0] m_ctrl[2];
    logic [31:0] m_rld[2];
    logic [31:0] m_cur[2];
    bit          m_stat[2];
    bit          m_pend[2];

    tmr_pair u0 (.clk(clk), .rst_n(rst_n), .tick(tick), .hw_en(hw_en),
                 .wr_en(wr_en), .addr(addr), .wdata(wdata), .rd_data(rd_data),
                 .irq(irq), .pwm_out(pwm_out));

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mread(input logic [3:0] a);
        int c = a[3];
        case (a[2:0])
            3'd0:    return m_ctrl[c] | (32'(m_stat[c]) << 16);
            3'd1:    return m_rld[c];
            3'd2:    return m_cur[c];
            default: return 32'd0;
        endcase
    endfunction

    // Advance the model by one clock with the given inputs.
    task automatic model(input bit wr, input logic [3:0] a, input logic [31:0] d,
                         input bit tk, input logic [1:0] hw);
        for (int c = 0; c < 2; c++) begin
            bit run, wc, wr_r, wcur, evt;
            run  = (m_ctrl[c][20:19] != 2'd0) && m_ctrl[c][18] && (hw[c] == m_ctrl[c][17]);
            wc   = wr && a[3] == c[0] && a[2:0] == 3'd0;
            wr_r = wr && a[3] == c[0] && a[2:0] == 3'd1;
            wcur = wr && a[3] == c[0] && a[2:0] == 3'd2;
            evt  = 1'b0;
            if (wc) begin
                m_ctrl[c] = d & 32'h007E_0000;
                m_pend[c] = 1'b0;
                if (d[20:19] != 2'd3) m_stat[c] = 1'b0;
            end
            if (wr_r) begin
                m_rld[c] = d;
                if (!run) m_cur[c] = d;
            end
            if (wcur) m_cur[c] = d;
            if (!(wc || wr_r || wcur) && tk && run) begin
                if (m_cur[c] != 0) m_cur[c] = m_cur[c] - 1;
                else if (m_ctrl[c][20:19] == 2'd1) begin
                    if (m_ctrl[c][21]) begin m_cur[c] = 32'hFFFF_FFFF; evt = 1'b1; end
                end else begin
                    m_cur[c] = m_rld[c];
                    evt = 1'b1;
                    if (m_ctrl[c][20:19] == 2'd3) m_stat[c] = !m_stat[c];
                end
            end
            if (evt) m_pend[c] = 1'b1;
        end
    endtask

    // One driven clock cycle, then compare irq and pwm_out.
    task automatic step(input bit wr, input logic [3:0] a, input logic [31:0] d,
                        input bit tk, input logic [1:0] hw, input string tag);
        logic [1:0] ei, ep;
        @(negedge clk);
        wr_en = wr; addr = a; wdata = d; tick = tk; hw_en = hw;
        model(wr, a, d, tk, hw);
        @(posedge clk);
        #1;
        wr_en = 1'b0; tick = 1'b0;
        ei = {m_pend[1] & m_ctrl[1][22], m_pend[0] & m_ctrl[0][22]};
        ep = {m_stat[1], m_stat[0]};
        chk(irq === ei, {tag, " irq"}, 32'(irq), 32'(ei));
        chk(pwm_out === ep, {tag, " pwm_out"}, 32'(pwm_out), 32'(ep));
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0; addr = a;
        #1;
        chk(rd_data === exp, tag, rd_data, exp);
    endtask

    task automatic ticks(input int n, input logic [1:0] hw, input string tag);
        for (int k = 0; k < n; k++) step(1'b0, 4'd0, 32'd0, 1'b1, hw, tag);
    endtask

    initial begin
        for (int c = 0; c < 2; c++) begin
            m_ctrl[c] = 0; m_rld[c] = 0; m_cur[c] = 0; m_stat[c] = 0; m_pend[c] = 0;
        end
        void'($urandom(32'd2024));
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        foreach (m_cur[c]) begin
            rd({c[0], 3'd0}, 32'd0, "R1 ctrl after reset");
            rd({c[0], 3'd1}, 32'd0, "R1 reload after reset");
            rd({c[0], 3'd2}, 32'd0, "R1 count after reset");
        end
        chk(irq === 2'b00 && pwm_out === 2'b00, "R1 outputs after reset", {30'd0, irq}, 32'd0);

        // R9: reload written while halted also loads count
        step(1'b1, 4'd1, 32'd5, 1'b0, 2'b00, "R9");
        rd(4'd2, 32'd5, "R9 count loaded by halted reload write");
        rd(4'd1, 32'd5, "R2 reload word");

        // R3: only the defined control bits are stored
        step(1'b1, 4'd0, 32'hFFFF_FFFF, 1'b0, 2'b00, "R3");
        rd(4'd0, 32'h007E_0000, "R3 control read-back mask");

        // R4: auto-reload, run, polarity 1, interrupt enabled
        step(1'b1, 4'd0, 32'h0056_0000, 1'b0, 2'b00, "R4");
        ticks(3, 2'b01, "R4");
        rd(4'd2, 32'd2, "R4 three decrements");
        ticks(2, 2'b00, "R4 pin mismatch");
        rd(4'd2, 32'd2, "R4 hold on polarity mismatch");

        // R5 and R8: reload at zero, interrupt raised
        ticks(2, 2'b01, "R5");
        rd(4'd2, 32'd0, "R5 reached zero");
        chk(irq[0] === 1'b0, "R8 no irq before event", 32'(irq[0]), 32'd0);
        ticks(1, 2'b01, "R5");
        rd(4'd2, 32'd5, "R5 reload on zero event");
        chk(irq[0] === 1'b1, "R8 irq after zero event", 32'(irq[0]), 32'd1);

        // R9: reload write while running leaves count alone
        step(1'b1, 4'd1, 32'd9, 1'b1, 2'b01, "R9");
        rd(4'd2, 32'd5, "R9 running reload write keeps count");
        step(1'b1, 4'd0, 32'h0056_0000, 1'b0, 2'b01, "R8");
        chk(irq[0] === 1'b0, "R8 control write clears pending", 32'(irq[0]), 32'd0);

        // R10: count write beats a simultaneous tick
        step(1'b1, 4'd2, 32'd3, 1'b1, 2'b01, "R10");
        rd(4'd2, 32'd3, "R10 tick dropped on write");
        rd(4'd10, 32'd0, "R11 other channel untouched");

        // R6: channel 1 free-running with wrap, polarity 0
        step(1'b1, 4'd8, 32'h002C_0000, 1'b0, 2'b00, "R6");
        ticks(1, 2'b00, "R6");
        rd(4'd10, 32'hFFFF_FFFF, "R6 wrap to all ones");
        rd(4'd2, 32'd3, "R11 halted channel 0 unchanged");
        step(1'b1, 4'd8, 32'h000C_0000, 1'b0, 2'b00, "R6");
        step(1'b1, 4'd10, 32'd1, 1'b0, 2'b00, "R6");
        ticks(3, 2'b00, "R6");
        rd(4'd10, 32'd0, "R6 rests at zero without wrap");

        // R7: wave mode on channel 0, reload 2
        step(1'b1, 4'd0, 32'h001E_0000, 1'b0, 2'b00, "R7");
        step(1'b1, 4'd1, 32'd2, 1'b0, 2'b00, "R7");
        rd(4'd2, 32'd2, "R9 halted reload write");
        ticks(2, 2'b01, "R7");
        chk(pwm_out[0] === 1'b0, "R7 no toggle before zero", 32'(pwm_out[0]), 32'd0);
        ticks(1, 2'b01, "R7");
        chk(pwm_out[0] === 1'b1, "R7 toggle on zero event", 32'(pwm_out[0]), 32'd1);
        rd(4'd0, 32'h001F_0000, "R7 status bit in control");
        ticks(3, 2'b01, "R7");
        chk(pwm_out[0] === 1'b0, "R7 second toggle", 32'(pwm_out[0]), 32'd0);
        ticks(3, 2'b01, "R7");
        step(1'b1, 4'd0, 32'h0014_0000, 1'b0, 2'b01, "R7");
        chk(pwm_out[0] === 1'b0, "R7 mode change clears status", 32'(pwm_out[0]), 32'd0);

        // R2: unmapped word ignored
        step(1'b1, 4'd3, 32'hFFFF_FFFF, 1'b0, 2'b00, "R2");
        rd(4'd3, 32'd0, "R2 unmapped reads zero");
        rd(4'd1, 32'd2, "R2 reload unchanged by unmapped write");

        // Constrained random phase checked against the model (R4-R11)
        for (int n = 0; n < 4000; n++) begin
            int r = $urandom % 16;
            logic [3:0] a = {1'($urandom), 3'($urandom % 4)};
            if (r < 2) begin
                logic [31:0] d = (a[2:0] == 3'd0) ? $urandom : ($urandom % 8);
                step(1'b1, a, d, 1'($urandom), 2'($urandom), "R10 random write");
            end else if (r == 2) begin
                rd(a, mread(a), "R11 random read");
            end else begin
                step(1'b0, 4'd0, 32'd0, ($urandom % 4) != 0, 2'($urandom), "R4 random tick");
            end
        end
        for (int k = 0; k < 16; k++) rd(4'(k), mread(4'(k)), "R2 final read");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end
endmodule